// File: doc/BRIEF.md
# Inbound Memory-Write Packet Sink

This block sits behind a packet port that delivers inbound transaction packets one 32-bit double-word per valid beat. A start strobe marks the first double-word of each packet. The block reads the format and type fields of that first double-word. For a memory write, it finds the target address in the last header double-word. That header has three double-words when the address is 32-bit and four when it is 64-bit. The payload beats that follow are written into a local window of double-word storage, one beat per location, at consecutive addresses.

Writes are gated by an externally supplied memory-space enable, normally bit 0 of the command register that lives elsewhere. A packet that starts while the enable is low is dropped. A payload beat that arrives while the enable is low is not stored. Request types that expect an answer raise a one-cycle completion-required pulse for a separate responder. Every other packet is consumed without touching storage. A synchronous read port gives access to the stored contents.

The window holds 2^IDX_W double-words and is indexed by byte-address bits [IDX_W+1:2]. IDX_W = 14 gives the full 64 KB window. The default of 10 keeps elaboration small.

Top module: `pkt_mwr_sink`

## Requirements
- R1: After reset, cpl_req is 0 and no storage write takes place until a packet has been parsed.
- R2: A start beat with bits 30:29 = 2'b10 and bits 28:24 = 5'b00000 is a memory write with a 3-double-word header. Double-word 2 carries the byte address, and the first payload beat that follows it is written at index addr[IDX_W+1:2].
- R3: With bits 30:29 = 2'b11 and type 5'b00000, the header has 4 double-words. Double-word 2 (upper address) does not select the location, and double-word 3 supplies the index as in R2.
- R4: Bits 9:0 of the start beat give the payload length in double-words, with 0 meaning 1024. Each payload beat goes to the next index, and the index wraps inside the window. Beats after the last one are not written.
- R5: A memory write whose start beat arrives while mem_en is 0 changes no storage. A payload beat that arrives while mem_en is 0 is not stored.
- R6: A packet that is not a memory write, including one that carries data, leaves storage unchanged.
- R7: cpl_req pulses high for exactly the cycle after a start beat, unless that beat is a memory write or a message (bits 28:27 = 2'b10).
- R8: A start beat in the middle of a packet abandons the current packet and begins parsing a new header.
- R9: Beats with in_vld low are ignored, so gaps inside a packet do not change its result.
- R10: rd_data shows the word at rd_idx one clock after rd_idx is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_en | input | 1 | Memory-space enable from the command register |
| in_vld | input | 1 | Beat valid |
| in_sop | input | 1 | First double-word of a packet |
| in_dw | input | 32 | Packet double-word |
| cpl_req | output | 1 | One-cycle pulse: the packet needs a completion |
| rd_idx | input | IDX_W | Read index into the window |
| rd_data | output | 32 | Registered read data |

## Verification
Memory writes are sent with both header lengths, so a mix-up between the 3- and 4-double-word forms shows up as data stored at the wrong index. Further packets test the following:
- Stalled beats check R9.
- An enable that is low at the start beat, or drops in mid-payload, checks R5.
- A read, a configuration write with data, and a message check that they cause no stores and that the completion flag is correct for each.
- A packet cut short by a new start beat checks R8.
- A 1024-beat write, whose length field is zero, proves the length encoding and the index wrap, since it overwrites the whole window and ends just below its start.

// File: rtl/pkt_mwr_sink.sv
module pkt_mwr_sink #(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mem_en,
  input  logic             in_vld,
  input  logic             in_sop,
  input  logic [31:0]      in_dw,
  output logic             cpl_req,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [31:0]      rd_data
);
  localparam int DEPTH = 1 << IDX_W;

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_DATA} st_t;

  st_t              st;
  logic [1:0]       cnt, last;
  logic             keep;
  logic [10:0]      rem;
  logic [IDX_W-1:0] idx;
  logic [31:0]      mem [DEPTH];

  wire  is_mwr = in_dw[30] && (in_dw[28:24] == 5'b00000);
  wire  is_msg = (in_dw[28:27] == 2'b10);
  wire  [9:0] len = in_dw[9:0];
  wire  wr_en = in_vld && !in_sop && (st == S_DATA) && mem_en;

  logic unused_bits;
  assign unused_bits = ^in_dw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      last    <= '0;
      keep    <= 1'b0;
      rem     <= '0;
      idx     <= '0;
      cpl_req <= 1'b0;
    end else begin
      cpl_req <= 1'b0;
      if (in_vld) begin
        if (in_sop) begin
          st      <= S_HDR;
          cnt     <= 2'd1;
          last    <= in_dw[29] ? 2'd3 : 2'd2;
          keep    <= is_mwr && mem_en;
          rem     <= {(len == 10'd0), len};
          cpl_req <= !(is_mwr || is_msg);
        end else begin
          case (st)
            S_HDR: begin
              cnt <= cnt + 2'd1;
              if (cnt == last) begin
                idx <= in_dw[IDX_W+1:2];
                st  <= keep ? S_DATA : S_IDLE;
              end
            end
            S_DATA: begin
              idx <= idx + 1'b1;
              rem <= rem - 11'd1;
              if (rem == 11'd1) st <= S_IDLE;
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[idx] <= in_dw;
    rd_data <= mem[rd_idx];
  end
endmodule

module pkt_mwr_sink_chk #(
  parameter int IDX_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mem_en,
  input logic             in_vld,
  input logic             in_sop,
  input logic             wr_en,
  input logic             cpl_req,
  input logic [IDX_W-1:0] idx,
  input logic [10:0]      rem
);
  // R5
  wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> mem_en);

  // R9
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |-> !wr_en);

  // R7
  cpl_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_req |-> $past(in_vld && in_sop));

  // R8
  sop_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_sop) |=> !wr_en);

  // R4
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (idx == IDX_W'($past(idx) + 1'b1)));

  // R4
  len_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rem == 11'd1) |=> !wr_en);
endmodule

bind pkt_mwr_sink pkt_mwr_sink_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_en(mem_en), .in_vld(in_vld),
  .in_sop(in_sop), .wr_en(wr_en), .cpl_req(cpl_req), .idx(idx), .rem(rem)
);

// File: tb/pkt_mwr_sink_bench.sv
`timescale 1ns/1ps
module pkt_mwr_sink_bench;
  localparam int IDX_W = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             mem_en = 1'b1;
  logic             in_vld = 1'b0;
  logic             in_sop = 1'b0;
  logic [31:0]      in_dw = '0;
  logic             cpl_req;
  logic [IDX_W-1:0] rd_idx = '0;
  logic [31:0]      rd_data;

  int total = 0;
  int fails = 0;
  bit done = 0;

  pkt_mwr_sink #(.IDX_W(IDX_W)) u_pkt_mwr_sink (
    .clk(clk), .rst_n(rst_n), .mem_en(mem_en), .in_vld(in_vld),
    .in_sop(in_sop), .in_dw(in_dw), .cpl_req(cpl_req),
    .rd_idx(rd_idx), .rd_data(rd_data)
  );

  always #2.5 clk = ~clk;

  function automatic logic [31:0] hdr0(input logic [1:0] fmt, input logic [4:0] typ,
                                       input logic [9:0] len);
    return {1'b0, fmt, typ, 14'b0, len};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic beat(input logic [31:0] d, input logic s);
    in_vld = 1'b1; in_sop = s; in_dw = d;
    @(posedge clk); #1;
    in_vld = 1'b0; in_sop = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic rd(input int i, input logic [31:0] exp, input string req);
    rd_idx = IDX_W'(i);
    @(posedge clk); #1;
    check(req, rd_data, exp);
  endtask

  task automatic mwr32(input int i, input logic [31:0] d);
    beat(hdr0(2'b10, 5'd0, 10'd1), 1'b1);
    beat(32'h0, 1'b0);
    beat(32'(i) << 2, 1'b0);
    beat(d, 1'b0);
  endtask

  task automatic t_reset;
    check("R1 cpl_req after reset", {31'b0, cpl_req}, 32'd0);
    idle(3);
    check("R1 cpl_req idle", {31'b0, cpl_req}, 32'd0);
  endtask

  task automatic t_mwr32;
    beat(hdr0(2'b10, 5'd0, 10'd4), 1'b1);
    check("R7 no cpl for write", {31'b0, cpl_req}, 32'd0);
    beat(32'h0000_00ff, 1'b0);
    beat(32'h0000_0040, 1'b0);
    for (int k = 0; k < 4; k++) beat(32'hA000_0000 + k, 1'b0);
    beat(32'hDEAD_BEEF, 1'b0);
    rd(16, 32'hA000_0000, "R10 read port");
    for (int k = 0; k < 4; k++) rd(16 + k, 32'hA000_0000 + k, "R2 3dw write");
    rd(20, 32'h0, "R4 beat past length not stored");
  endtask

  task automatic t_pre;
    mwr32(20, 32'h0);
  endtask

  task automatic t_mwr64;
    beat(hdr0(2'b11, 5'd0, 10'd2), 1'b1);
    beat(32'h0, 1'b0);
    beat(32'h0000_0001, 1'b0);
    beat(32'h0000_0100, 1'b0);
    beat(32'hB000_0000, 1'b0);
    beat(32'hB000_0001, 1'b0);
    rd(64, 32'hB000_0000, "R3 4dw write");
    rd(65, 32'hB000_0001, "R3 4dw write");
  endtask

  task automatic t_stall;
    beat(hdr0(2'b10, 5'd0, 10'd3), 1'b1);
    idle(2);
    beat(32'h0, 1'b0);
    beat(32'd100 << 2, 1'b0);
    idle(1);
    beat(32'hC000_0000, 1'b0);
    idle(3);
    beat(32'hC000_0001, 1'b0);
    beat(32'hC000_0002, 1'b0);
    for (int k = 0; k < 3; k++) rd(100 + k, 32'hC000_0000 + k, "R9 stalled beats");
  endtask

  task automatic t_gate;
    mem_en = 1'b0;
    mwr32(16, 32'h1111_1111);
    mem_en = 1'b1;
    rd(16, 32'hA000_0000, "R5 disabled at start");
    mwr32(201, 32'h0000_0055);
    beat(hdr0(2'b10, 5'd0, 10'd3), 1'b1);
    beat(32'h0, 1'b0);
    beat(32'd200 << 2, 1'b0);
    beat(32'hD000_0000, 1'b0);
    mem_en = 1'b0;
    beat(32'hD000_0001, 1'b0);
    mem_en = 1'b1;
    beat(32'hD000_0002, 1'b0);
    rd(200, 32'hD000_0000, "R5 enabled beat");
    rd(201, 32'h0000_0055, "R5 disabled beat");
    rd(202, 32'hD000_0002, "R5 enabled again");
  endtask

  task automatic t_nonwr;
    beat(hdr0(2'b00, 5'd0, 10'd1), 1'b1);
    check("R7 read needs cpl", {31'b0, cpl_req}, 32'd1);
    beat(32'h0, 1'b0);
    check("R7 pulse one cycle", {31'b0, cpl_req}, 32'd0);
    beat(32'd16 << 2, 1'b0);
    beat(hdr0(2'b10, 5'b00100, 10'd1), 1'b1);
    check("R7 cfg write needs cpl", {31'b0, cpl_req}, 32'd1);
    beat(32'h0, 1'b0);
    beat(32'd16 << 2, 1'b0);
    beat(32'h2222_2222, 1'b0);
    rd(16, 32'hA000_0000, "R6 cfg write data ignored");
    beat(hdr0(2'b11, 5'b10000, 10'd1), 1'b1);
    check("R7 message no cpl", {31'b0, cpl_req}, 32'd0);
    beat(32'h0, 1'b0);
    beat(32'h0, 1'b0);
    beat(32'd16 << 2, 1'b0);
    beat(32'h3333_3333, 1'b0);
    rd(16, 32'hA000_0000, "R6 message data ignored");
  endtask

  task automatic t_abort;
    mwr32(301, 32'h0000_0077);
    beat(hdr0(2'b10, 5'd0, 10'd4), 1'b1);
    beat(32'h0, 1'b0);
    beat(32'd300 << 2, 1'b0);
    beat(32'hE000_0000, 1'b0);
    beat(hdr0(2'b10, 5'd0, 10'd1), 1'b1);
    beat(32'h0, 1'b0);
    beat(32'd310 << 2, 1'b0);
    beat(32'hE000_0010, 1'b0);
    rd(300, 32'hE000_0000, "R8 beat before abort");
    rd(301, 32'h0000_0077, "R8 abandoned packet");
    rd(310, 32'hE000_0010, "R8 new packet");
  endtask

  task automatic t_len1024;
    beat(hdr0(2'b10, 5'd0, 10'd0), 1'b1);
    beat(32'h0, 1'b0);
    beat(32'd5 << 2, 1'b0);
    for (int k = 0; k < 1024; k++) beat(32'hF000_0000 | k, 1'b0);
    rd(5, 32'hF000_0000, "R4 first of 1024");
    rd(500, 32'hF000_0000 | 495, "R4 middle of 1024");
    rd(4, 32'hF000_0000 | 1023, "R4 wrap to last");
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    #1;
    t_reset;
    t_pre;
    t_mwr32;
    t_mwr64;
    t_stall;
    t_gate;
    t_nonwr;
    t_abort;
    t_len1024;
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule